// File: doc/BRIEF.md
# Variable-Latency Column-Bypass Multiplier

This block multiplies two unsigned operands and returns the product after one or two clock cycles, depending on the operand bit pattern. The datapath is an array of adder columns, one per multiplicand bit. A column whose multiplicand bit is zero is skipped, and its partial sum passes straight on. The more zero bits the multiplicand holds, the shorter the real path through the array. A hold judge counts those zero bits. It lets the product be taken after one cycle when the count reaches a threshold, and otherwise holds the operation for a second cycle.

When slowed silicon is expected, an aging input raises the threshold by one. The judge then sends fewer operand pairs down the fast path. A shadow-latch error flag reports when a one-cycle capture was too early. The block then throws that result away and recomputes the same operands with the two-cycle timing.

The controller is a four-state machine:
- ST_IDLE waits for start. On start it captures the operands and the aging level, then moves to ST_EXEC.
- ST_EXEC evaluates the operation:
  - a short operation with no error flag loads the product, pulses valid and returns to ST_IDLE;
  - a short operation with the error flag moves to ST_RETRY;
  - a long operation moves to ST_HOLD.
- ST_RETRY spends the discarded cycle and moves to ST_HOLD.
- ST_HOLD loads the product, pulses valid and returns to ST_IDLE.

Top module: `vl_bypass_mult`

## Requirements
- R1: `product` equals the unsigned product of the captured operands (32 bits at the default 16-bit width). It changes only in the cycle in which `valid` is high, and it holds its value until the next result.
- R2: With `aging` low at start, a multiplicand containing 8 or more zero bits gives `valid` high right after the first rising edge that follows the start edge (latency 1).
- R3: A multiplicand with fewer zero bits than the active threshold gives latency 2.
- R4: With `aging` high at start, the threshold is 9 zero bits instead of 8.
- R5: `aging` is sampled only on the edge that accepts a start. Changing it during an operation leaves that operation's latency unchanged.
- R6: The error flag counts for a short operation only when `tm_err` is high in the cycle after the start edge. In that case:
  - the short result is discarded and `valid` stays low;
  - the same operands are recomputed;
  - the result arrives with latency 3.
- R7: `tm_err` has no effect when it is high in any other cycle, and no effect during a long operation.
- R8: `busy` rises on the edge that accepts a start and falls on the edge at which `valid` rises. `valid` is a single-cycle pulse, and `busy` is low while `valid` is high.
- R9: A `start` pulse seen while `busy` is high is ignored. It produces no result and does not disturb the operation in progress.
- R10: While `rst_n` is low and right after reset, `product` is 0 and both `valid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication with the present operands |
| mcand | input | W (16) | Multiplicand; its zero bits decide the latency |
| mplier | input | W (16) | Multiplier |
| aging | input | 1 | High selects the stricter one-cycle threshold |
| tm_err | input | 1 | Shadow-latch timing error for the one-cycle capture |
| product | output | 2W (32) | Registered product |
| valid | output | 1 | One-cycle pulse marking a new product |
| busy | output | 1 | An operation is in progress |

## Verification
The hardest situation to reach is a timing error that lands in exactly the one cycle where it matters. That cycle is the evaluation cycle of an operand pair that sits right at the zero-count threshold. The driver places the `tm_err` pulse at a chosen cycle offset after the start edge, using multiplicands with exactly 8 or 9 zero bits. The same pulse is also moved one cycle later, and applied to long operations, to show it is ignored there. A further test flips `aging` in the cycle after the start edge, and another sends a second start into the busy window.

// File: rtl/vlm_pkg.sv
`timescale 1ns/1ps
package vlm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXEC  = 2'd1,
        ST_RETRY = 2'd2,
        ST_HOLD  = 2'd3
    } vlm_state_e;
endpackage

// File: rtl/vlm_hold_judge.sv
`timescale 1ns/1ps
// Counts zero bits of the multiplicand and decides one- or two-cycle timing.
module vlm_hold_judge #(
    parameter int W       = 16,
    parameter int TH_NORM = 8,
    parameter int TH_AGED = 9,
    localparam int CW     = $clog2(W + 1)
) (
    input  logic [W-1:0] mcand,
    input  logic         aged,
    output logic         one_cycle
);
    logic [CW-1:0] zeros;
    logic [CW-1:0] thresh;

    always_comb begin
        zeros = '0;
        for (int i = 0; i < W; i++) begin
            zeros = zeros + CW'(!mcand[i]);
        end
    end

    assign thresh    = aged ? CW'(TH_AGED) : CW'(TH_NORM);
    assign one_cycle = (zeros >= thresh);
endmodule

// File: rtl/vlm_bypass_array.sv
`timescale 1ns/1ps
// One adder column per multiplicand bit; a zero bit bypasses its column.
module vlm_bypass_array #(
    parameter int W  = 16,
    localparam int PW = 2 * W
) (
    input  logic [W-1:0]  mcand,
    input  logic [W-1:0]  mplier,
    output logic [PW-1:0] prod
);
    logic [PW-1:0] acc [0:W];

    assign acc[0] = '0;

    for (genvar g = 0; g < W; g++) begin : g_col
        logic [PW-1:0] addend;
        assign addend     = {{W{1'b0}}, mplier} << g;
        assign acc[g + 1] = mcand[g] ? (acc[g] + addend) : acc[g];
    end

    assign prod = acc[W];
endmodule

// File: rtl/vlm_ctrl.sv
`timescale 1ns/1ps
module vlm_ctrl
    import vlm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic one_cycle,
    input  logic tm_err,
    output logic capture,
    output logic load,
    output logic valid,
    output logic busy
);
    vlm_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_EXEC;
            ST_EXEC: begin
                if (!one_cycle)  state_nx = ST_HOLD;
                else if (tm_err) state_nx = ST_RETRY;
                else             state_nx = ST_IDLE;
            end
            ST_RETRY: state_nx = ST_HOLD;
            ST_HOLD:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        capture = (state == ST_IDLE) && start;
        load    = ((state == ST_EXEC) && one_cycle && !tm_err) || (state == ST_HOLD);
        busy    = (state != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= load;
    end
endmodule

// File: rtl/vl_bypass_mult.sv
`timescale 1ns/1ps
module vl_bypass_mult #(
    parameter int W       = 16,
    parameter int TH_NORM = 8,
    parameter int TH_AGED = 9,
    localparam int PW     = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  mcand,
    input  logic [W-1:0]  mplier,
    input  logic          aging,
    input  logic          tm_err,
    output logic [PW-1:0] product,
    output logic          valid,
    output logic          busy
);
    logic [W-1:0]  a_q, b_q;
    logic          aged_q;
    logic          one_cycle, capture, load;
    logic [PW-1:0] arr_prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            aged_q <= 1'b0;
        end else if (capture) begin
            a_q    <= mcand;
            b_q    <= mplier;
            aged_q <= aging;
        end
    end

    vlm_hold_judge #(.W(W), .TH_NORM(TH_NORM), .TH_AGED(TH_AGED)) u_judge (
        .mcand     (a_q),
        .aged      (aged_q),
        .one_cycle (one_cycle)
    );

    vlm_bypass_array #(.W(W)) u_array (
        .mcand  (a_q),
        .mplier (b_q),
        .prod   (arr_prod)
    );

    vlm_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .one_cycle (one_cycle),
        .tm_err    (tm_err),
        .capture   (capture),
        .load      (load),
        .valid     (valid),
        .busy      (busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    product <= '0;
        else if (load) product <= arr_prod;
    end
endmodule

// File: rtl/vlm_checker.sv
`timescale 1ns/1ps
module vlm_checker #(
    parameter int W  = 16,
    localparam int PW = 2 * W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          valid,
    input logic          busy,
    input logic [PW-1:0] product,
    input logic [W-1:0]  a_q,
    input logic [W-1:0]  b_q
);
    // R1
    prod_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (product == ({{W{1'b0}}, a_q} * {{W{1'b0}}, b_q})));
    // R1
    prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(product));
    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !busy);
    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> valid);
    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
endmodule

bind vl_bypass_mult vlm_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .valid   (valid),
    .busy    (busy),
    .product (product),
    .a_q     (a_q),
    .b_q     (b_q)
);

// File: tb/sim_vl_bypass_mult.sv
`timescale 1ns/1ps
module sim_vl_bypass_mult;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] mcand = '0;
    logic [15:0] mplier = '0;
    logic        aging = 1'b0;
    logic        tm_err = 1'b0;
    logic [31:0] product;
    logic        valid;
    logic        busy;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] p;
        int          lat;
        int          start_cyc;
        string       tag;
    } exp_t;
    exp_t sb[$];

    vl_bypass_mult u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
        .aging(aging), .tm_err(tm_err), .product(product), .valid(valid), .busy(busy)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pop expected items as results appear
    always @(negedge clk) begin
        if (rst_n && valid && !done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9 unexpected valid", 1, 0);
            end else begin
                exp_t it;
                it = sb.pop_front();
                chk(product == it.p, "R1 product", longint'(product), longint'(it.p));
                chk((cyc - it.start_cyc) == it.lat, it.tag, cyc - it.start_cyc, it.lat);
                chk(busy == 1'b0, "R8 busy low with valid", busy, 0);
            end
        end
    end

    // errpos/ignpos: cycle index after the start edge (1 = evaluation cycle), 0 = never
    task automatic run_op(input logic [15:0] a, input logic [15:0] b, input logic ag,
                          input int errpos, input bit flip_ag, input int ignpos,
                          input string tag);
        int zeros;
        bit shrt;
        exp_t it;
        zeros = 16 - $countones(a);
        shrt  = (zeros >= (ag ? 9 : 8));
        it.p  = 32'(a) * 32'(b);
        it.lat = shrt ? ((errpos == 1) ? 3 : 1) : 2;
        it.tag = tag;
        @(negedge clk);
        it.start_cyc = cyc + 1;
        sb.push_back(it);
        start = 1'b1; mcand = a; mplier = b; aging = ag; tm_err = 1'b0;
        for (int j = 1; j < 20; j++) begin
            @(negedge clk);
            if (j == 1) chk(busy == 1'b1, "R8 busy after start", busy, 1);
            if (j >= 2 && !busy && errpos < j && ignpos < j) break;
            tm_err = (j == errpos);
            if (j == 1 && flip_ag) aging = ~ag;
            if (j == ignpos) begin
                start = 1'b1; mcand = ~a; mplier = b ^ 16'h5a5a;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0; tm_err = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(product == 32'd0 && !valid && !busy, "R10 reset state", {product, valid, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(product == 32'd0 && !valid && !busy, "R10 after reset", {product, valid, busy}, 0);

        run_op(16'h00FF, 16'h1234, 1'b0, 0, 1'b0, 0, "R2 latency 8 zeros normal");
        run_op(16'h00FF, 16'h4321, 1'b1, 0, 1'b0, 0, "R4 latency 8 zeros aged");
        run_op(16'h007F, 16'hBEEF, 1'b1, 0, 1'b0, 0, "R4 latency 9 zeros aged");
        run_op(16'h01FF, 16'h0F0F, 1'b0, 0, 1'b0, 0, "R3 latency 7 zeros");
        run_op(16'hFFFF, 16'hFFFF, 1'b0, 0, 1'b0, 0, "R3 latency all ones");
        run_op(16'h0000, 16'hABCD, 1'b0, 0, 1'b0, 0, "R2 latency zero mcand");
        run_op(16'h00FF, 16'h2222, 1'b0, 0, 1'b1, 0, "R5 aging rises mid op");
        run_op(16'h00FF, 16'h3333, 1'b1, 0, 1'b1, 0, "R5 aging falls mid op");
        run_op(16'h0F0F, 16'hCAFE, 1'b0, 1, 1'b0, 0, "R6 retry after error");
        run_op(16'h007F, 16'h8001, 1'b1, 1, 1'b0, 0, "R6 retry aged");
        run_op(16'hFF0F, 16'h1357, 1'b0, 1, 1'b0, 0, "R7 error on long op");
        run_op(16'h0F0F, 16'h2468, 1'b0, 2, 1'b0, 0, "R7 late error short op");
        run_op(16'h01FF, 16'h7777, 1'b0, 2, 1'b0, 0, "R7 error in hold cycle");
        run_op(16'h01FF, 16'h9999, 1'b0, 0, 1'b0, 1, "R9 start while busy");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!valid, "R9 no result from ignored start", valid, 0);
        end
        for (int k = 0; k < 40; k++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            ra = 16'($urandom) & 16'($urandom);
            rb = 16'($urandom);
            run_op(ra, rb, 1'($urandom), int'($urandom % 3), 1'b0, 0, "R3 latency random");
        end
        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule